// File: doc/BRIEF.md
# Parallel Camera Sensor Capture

This block accepts pixel samples from a parallel image sensor and queues them, tagged with frame and line markers, for a downstream consumer. The sensor side offers a data bus (20 bits by default), a frame sync, a line sync and a pixel clock. All four are brought into the system clock domain through two-flop synchronisers. Edges of the pixel clock are found there and used as sample strobes, so the system clock must run at least four times as fast as the pixel clock.

Capture has two modes. In gated mode the line sync qualifies pixels: only sampling edges seen while the line is active are kept, and the last pixel of each line is tagged as end of line. In non-gated mode the line sync is disregarded and every sampling edge stores one word. The frame-sync trigger edge, the line-sync active level and the pixel-clock sampling edge are all selectable. Mode, line level and sampling edge are taken over only at a frame-sync event, so no frame mixes two settings.

Samples enter a 16-entry FIFO that drains through a valid/ready stream. A sample that meets a full FIFO is discarded and raises a sticky overflow flag, which an explicit clear input resets.

Top module: `cam_capture`

## Requirements
- R1: After reset, out_valid and ovf_flag are 0, and no sample is stored until the first frame-sync event has been seen.
- R2: A frame-sync event is the configured edge of sen_fsync (rising when cfg_fs_fall is 0, falling when it is 1); the first stored sample after it has out_sof = 1 and every other sample has out_sof = 0.
- R3: One word is stored per sampling edge of sen_pclk (rising when the latched cfg_pclk_fall is 0, falling when it is 1); the opposite edge stores nothing, and out_data equals sen_data as it stood at that edge.
- R4: In gated mode (latched cfg_gated = 1) a sampling edge is stored only while the line sync is active (high when the latched cfg_ls_low is 0, low when it is 1); edges while the line is inactive are dropped.
- R5: In gated mode the final stored sample of each line has out_eol = 1 and all others on that line have out_eol = 0.
- R6: In non-gated mode (latched cfg_gated = 0) the line sync has no effect: every sampling edge is stored and out_eol is always 0.
- R7: While sen_pclk is held at a constant level, no sample is stored.
- R8: The FIFO holds 16 words, delivers them in arrival order, and keeps the head word (out_data, out_sof, out_eol) unchanged while out_valid is 1 and out_ready is 0.
- R9: A sample arriving while 16 words are queued is discarded and sets ovf_flag, which stays 1 until ovf_clr is asserted in a cycle with no new discard.
- R10: Changes on cfg_gated, cfg_ls_low and cfg_pclk_fall take effect only at the next frame-sync event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sen_data | input | DW | Sensor pixel data |
| sen_fsync | input | 1 | Sensor frame sync |
| sen_lsync | input | 1 | Sensor line sync |
| sen_pclk | input | 1 | Sensor pixel clock |
| cfg_gated | input | 1 | 1 = gated mode, 0 = non-gated mode |
| cfg_fs_fall | input | 1 | Frame-sync trigger edge: 0 rising, 1 falling |
| cfg_ls_low | input | 1 | Line-sync active level: 0 high, 1 low |
| cfg_pclk_fall | input | 1 | Pixel-clock sampling edge: 0 rising, 1 falling |
| out_valid | output | 1 | A queued word is available |
| out_ready | input | 1 | Consumer accepts the head word |
| out_data | output | DW | Head word pixel data |
| out_sof | output | 1 | Head word is the first sample of a frame |
| out_eol | output | 1 | Head word is the last sample of a line |
| ovf_flag | output | 1 | Sticky FIFO overflow flag |
| ovf_clr | input | 1 | Clears ovf_flag |

## Verification
On every cycle the assertions check the stream rules and the overflow flag: the head word stays still under back-pressure, the occupancy never exceeds 16, the flag only rises on a real discard and stays up until cleared, and the latched mode never moves outside a frame-sync event. What only the directed scenarios can show is the content of the stream: which pixel edges are kept in each mode and polarity, the placement of start-of-frame and end-of-line tags, that pixels before the first frame or between lines are lost, and that a mid-frame setting change is deferred to the following frame.

// File: rtl/cam_pkg.sv
package cam_pkg;
  // Settings that are captured at a frame-sync event
  typedef struct packed {
    logic gated;
    logic ls_low;
    logic pclk_fall;
  } cam_cfg_t;
endpackage

// File: rtl/cam_sync.sv
module cam_sync #(
  parameter int DW     = 20,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic          fs_in,
  input  logic          ls_in,
  input  logic          pclk_in,
  input  logic          fs_fall,
  input  logic          pclk_fall,
  output logic [DW-1:0] dout,
  output logic          ls_out,
  output logic          pix_evt,
  output logic          fs_evt
);
  localparam int W = DW + 3;

  logic [W-1:0] chain [STAGES];
  logic [W-1:0] tail;
  logic         pclk_d, fs_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= {din, fs_in, ls_in, pclk_in};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign tail = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_d <= 1'b0;
      fs_d   <= 1'b0;
    end else begin
      pclk_d <= tail[0];
      fs_d   <= tail[2];
    end
  end

  assign dout    = tail[W-1:3];
  assign ls_out  = tail[1];
  assign pix_evt = pclk_fall ? (pclk_d & ~tail[0]) : (~pclk_d & tail[0]);
  assign fs_evt  = fs_fall   ? (fs_d & ~tail[2])   : (~fs_d & tail[2]);
endmodule

// File: rtl/cam_framer.sv
module cam_framer
  import cam_pkg::*;
#(
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  cam_cfg_t      cfg_in,
  input  logic          pix_evt,
  input  logic          fs_evt,
  input  logic          ls_s,
  input  logic [DW-1:0] data_s,
  output cam_cfg_t      act,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic          push_sof,
  output logic          push_eol
);
  logic          armed, sof_pend, line_prev;
  logic          stg_v, stg_sof;
  logic [DW-1:0] stg_d;
  logic          line_act, line_end;

  assign line_act = ls_s ^ act.ls_low;
  assign line_end = line_prev & ~line_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= cfg_in;
      armed     <= 1'b0;
      sof_pend  <= 1'b0;
      line_prev <= 1'b0;
      stg_v     <= 1'b0;
      stg_sof   <= 1'b0;
      stg_d     <= '0;
      push      <= 1'b0;
      push_data <= '0;
      push_sof  <= 1'b0;
      push_eol  <= 1'b0;
    end else begin
      push      <= 1'b0;
      line_prev <= line_act;
      if (fs_evt) begin
        act      <= cfg_in;
        armed    <= 1'b1;
        sof_pend <= 1'b1;
        if (stg_v) begin
          push      <= 1'b1;
          push_data <= stg_d;
          push_sof  <= stg_sof;
          push_eol  <= 1'b1;
          stg_v     <= 1'b0;
        end
      end else if (armed) begin
        if (act.gated) begin
          if (pix_evt && line_act) begin
            if (stg_v) begin
              push      <= 1'b1;
              push_data <= stg_d;
              push_sof  <= stg_sof;
              push_eol  <= 1'b0;
            end
            stg_v    <= 1'b1;
            stg_d    <= data_s;
            stg_sof  <= sof_pend;
            sof_pend <= 1'b0;
          end else if (line_end && stg_v) begin
            push      <= 1'b1;
            push_data <= stg_d;
            push_sof  <= stg_sof;
            push_eol  <= 1'b1;
            stg_v     <= 1'b0;
          end
        end else if (pix_evt) begin
          push      <= 1'b1;
          push_data <= data_s;
          push_sof  <= sof_pend;
          push_eol  <= 1'b0;
          sof_pend  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cam_fifo.sv
module cam_fifo #(
  parameter int W     = 22,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  output logic                       full,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_wr, do_rd;

  assign full     = (count == CW'(DEPTH));
  assign rd_valid = (count != '0);
  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_valid && rd_ready;
  assign rd_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end
endmodule

// File: rtl/cam_capture.sv
module cam_capture
  import cam_pkg::*;
#(
  parameter int DW     = 20,
  parameter int DEPTH  = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sen_data,
  input  logic          sen_fsync,
  input  logic          sen_lsync,
  input  logic          sen_pclk,
  input  logic          cfg_gated,
  input  logic          cfg_fs_fall,
  input  logic          cfg_ls_low,
  input  logic          cfg_pclk_fall,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eol,
  output logic          ovf_flag,
  input  logic          ovf_clr
);
  localparam int W  = DW + 2;
  localparam int CW = $clog2(DEPTH + 1);

  cam_cfg_t      cfg_req, act_cfg;
  logic [DW-1:0] data_s, push_data;
  logic          ls_s, pix_evt, fs_evt;
  logic          smp_push, push_sof, push_eol;
  logic          fifo_full;
  logic [W-1:0]  head;
  logic [CW-1:0] fifo_cnt;
  logic          act_gated;

  assign cfg_req   = '{gated: cfg_gated, ls_low: cfg_ls_low, pclk_fall: cfg_pclk_fall};
  assign act_gated = act_cfg.gated;

  cam_sync #(.DW(DW), .STAGES(STAGES)) i_sync (
    .clk(clk), .rst(rst), .din(sen_data), .fs_in(sen_fsync), .ls_in(sen_lsync),
    .pclk_in(sen_pclk), .fs_fall(cfg_fs_fall), .pclk_fall(act_cfg.pclk_fall),
    .dout(data_s), .ls_out(ls_s), .pix_evt(pix_evt), .fs_evt(fs_evt)
  );

  cam_framer #(.DW(DW)) i_framer (
    .clk(clk), .rst(rst), .cfg_in(cfg_req), .pix_evt(pix_evt), .fs_evt(fs_evt),
    .ls_s(ls_s), .data_s(data_s), .act(act_cfg), .push(smp_push),
    .push_data(push_data), .push_sof(push_sof), .push_eol(push_eol)
  );

  cam_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .wr_en(smp_push), .wr_data({push_sof, push_eol, push_data}),
    .full(fifo_full), .rd_valid(out_valid), .rd_ready(out_ready), .rd_data(head),
    .count(fifo_cnt)
  );

  assign out_sof  = head[W-1];
  assign out_eol  = head[W-2];
  assign out_data = head[DW-1:0];

  // A discard in the same cycle as a clear keeps the flag set
  always_ff @(posedge clk) begin
    if (rst)                        ovf_flag <= 1'b0;
    else if (smp_push && fifo_full) ovf_flag <= 1'b1;
    else if (ovf_clr)               ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk #(
  parameter int DW    = 20,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [DW-1:0]              out_data,
  input logic                       out_sof,
  input logic                       out_eol,
  input logic                       ovf_flag,
  input logic                       ovf_clr,
  input logic                       fifo_full,
  input logic                       smp_push,
  input logic                       fs_evt,
  input logic                       act_gated,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !ovf_flag));

  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol)));

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(smp_push && fifo_full));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fs_evt |=> $stable(act_gated));
endmodule

bind cam_capture cam_capture_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol), .ovf_flag(ovf_flag),
  .ovf_clr(ovf_clr), .fifo_full(fifo_full), .smp_push(smp_push), .fs_evt(fs_evt),
  .act_gated(act_gated), .fifo_cnt(fifo_cnt)
);

// File: tb/test_cam_capture.sv
`timescale 1ns/1ps
module test_cam_capture;
  localparam int DW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] sen_data = '0;
  logic          sen_fsync = 1'b0, sen_lsync = 1'b0, sen_pclk = 1'b0;
  logic          cfg_gated = 1'b1, cfg_fs_fall = 1'b0, cfg_ls_low = 1'b0, cfg_pclk_fall = 1'b0;
  logic          out_valid, out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic          out_sof, out_eol, ovf_flag;
  logic          ovf_clr = 1'b0;

  int errors = 0, checks = 0;
  int col_n = 0;
  logic [DW-1:0] col_d [64];
  logic          col_s [64];
  logic          col_e [64];

  always #4 clk = ~clk;

  cam_capture i_cam_capture (
    .clk(clk), .rst(rst), .sen_data(sen_data), .sen_fsync(sen_fsync),
    .sen_lsync(sen_lsync), .sen_pclk(sen_pclk), .cfg_gated(cfg_gated),
    .cfg_fs_fall(cfg_fs_fall), .cfg_ls_low(cfg_ls_low), .cfg_pclk_fall(cfg_pclk_fall),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
  );

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && col_n < 64) begin
      col_d[col_n] = out_data;
      col_s[col_n] = out_sof;
      col_e[col_n] = out_eol;
      col_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_word(input int idx, input int d, input bit s, input bit e, input string req);
    chk(col_d[idx] == DW'(d), req, int'(col_d[idx]), d);
    chk(col_s[idx] == s, {req, " sof"}, int'(col_s[idx]), int'(s));
    chk(col_e[idx] == e, {req, " eol"}, int'(col_e[idx]), int'(e));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // One pixel: inactive phase then the sampling edge into the active phase
  task automatic pix(input int d, input bit fall);
    sen_data = DW'(d);
    sen_pclk = fall;
    cyc(4);
    sen_pclk = ~fall;
    cyc(4);
  endtask

  task automatic frame_evt(input bit fall);
    sen_fsync = ~fall;
    cyc(6);
    sen_fsync = fall;
    cyc(6);
  endtask

  task automatic line(input int base, input int n, input bit low, input bit fall);
    sen_lsync = ~low;
    cyc(4);
    for (int i = 0; i < n; i++) pix(base + i, fall);
    sen_lsync = low;
    cyc(8);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    chk(ovf_flag == 1'b0, "R1 ovf after reset", int'(ovf_flag), 0);
    sen_lsync = 1'b1;
    for (int i = 0; i < 3; i++) pix(16'h0A0 + i, 1'b0);
    sen_lsync = 1'b0;
    cyc(20);
    chk(col_n == 0, "R1 no capture before frame", col_n, 0);
  endtask

  task automatic t_gated;
    col_n = 0;
    frame_evt(1'b0);
    line(32'h100, 4, 1'b0, 1'b0);
    pix(32'hBAD, 1'b0);
    pix(32'hBAE, 1'b0);
    line(32'h200, 3, 1'b0, 1'b0);
    cyc(20);
    chk(col_n == 7, "R4 gated count", col_n, 7);
    chk_word(0, 32'h100, 1, 0, "R2 gated first");
    chk_word(1, 32'h101, 0, 0, "R3 gated data");
    chk_word(3, 32'h103, 0, 1, "R5 line end");
    chk_word(4, 32'h200, 0, 0, "R4 skip off-line edges");
    chk_word(6, 32'h202, 0, 1, "R5 second line end");
  endtask

  task automatic t_nongated;
    col_n = 0;
    cfg_gated = 1'b0;
    cfg_pclk_fall = 1'b1;
    cfg_fs_fall = 1'b1;
    sen_fsync = 1'b1;
    sen_pclk = 1'b0;
    cyc(8);
    frame_evt(1'b1);
    for (int i = 0; i < 5; i++) begin
      sen_lsync = i[0];
      pix(32'h300 + i, 1'b1);
    end
    cyc(20);
    chk(col_n == 5, "R6 nongated count", col_n, 5);
    chk_word(0, 32'h300, 1, 0, "R2 nongated first");
    chk_word(2, 32'h302, 0, 0, "R3 falling edge data");
    chk_word(4, 32'h304, 0, 0, "R6 no eol");
    cyc(40);
    chk(col_n == 5, "R7 idle clock stores nothing", col_n, 5);
  endtask

  task automatic t_latch;
    col_n = 0;
    cfg_gated = 1'b1;
    cfg_ls_low = 1'b1;
    sen_lsync = 1'b1;
    cyc(4);
    pix(32'h400, 1'b1);
    pix(32'h401, 1'b1);
    cyc(20);
    chk(col_n == 2, "R10 old mode kept mid-frame", col_n, 2);
    chk_word(1, 32'h401, 0, 0, "R10 old mode data");
    frame_evt(1'b1);
    pix(32'hBBB, 1'b1);
    pix(32'hBBC, 1'b1);
    cyc(20);
    chk(col_n == 2, "R10 new mode line inactive", col_n, 2);
    line(32'h500, 2, 1'b1, 1'b1);
    cyc(20);
    chk(col_n == 4, "R4 active-low line count", col_n, 4);
    chk_word(2, 32'h500, 1, 0, "R10 new frame first");
    chk_word(3, 32'h501, 0, 1, "R5 active-low line end");
  endtask

  task automatic t_ovf;
    col_n = 0;
    cfg_gated = 1'b0;
    cfg_pclk_fall = 1'b0;
    cfg_fs_fall = 1'b0;
    sen_fsync = 1'b0;
    cyc(8);
    out_ready = 1'b0;
    frame_evt(1'b0);
    for (int i = 0; i < 20; i++) pix(32'h600 + i, 1'b0);
    cyc(10);
    chk(col_n == 0, "R8 nothing leaves while stalled", col_n, 0);
    chk(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
    chk(ovf_flag == 1'b1, "R9 overflow set", int'(ovf_flag), 1);
    out_ready = 1'b1;
    cyc(30);
    chk(col_n == 16, "R8 depth 16", col_n, 16);
    chk_word(0, 32'h600, 1, 0, "R8 order first");
    for (int i = 1; i < 16; i++) chk_word(i, 32'h600 + i, 0, 0, "R8 order");
    chk(ovf_flag == 1'b1, "R9 sticky", int'(ovf_flag), 1);
    ovf_clr = 1'b1;
    cyc(1);
    ovf_clr = 1'b0;
    cyc(2);
    chk(ovf_flag == 1'b0, "R9 cleared", int'(ovf_flag), 0);
  endtask

  bit done = 1'b0;

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(3);
    t_reset;
    t_gated;
    t_nongated;
    t_latch;
    t_ovf;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1-R10 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule